// File: doc/BRIEF.md
# Encoder Speed Meter

This block turns the pulse train of a single-channel photoelectric shaft encoder into a speed reading in revolutions per minute. An internal timer opens a fixed gate window, and the rising edges of the encoder signal are counted while it is open. The window length is set from the encoder resolution: with R pulses per revolution, a window of 60/R seconds holds exactly one edge per r/min. The closing count is therefore the speed itself, and no divider is needed. With 1024 pulses per revolution the window is 60/1024 s = 0.05859375 s, which is 1,464,844 cycles of a 25 MHz clock after rounding.

The encoder input is asynchronous. It passes through a two-flop synchronizer and then an edge detector. When a window closes, the total count is copied into the output register, a one-cycle strobe is raised, and counting starts again from zero in the next window. The count stops at its all-ones value instead of wrapping. A speed controller reads the value each time the strobe fires.

Top module: `enc_speed_meter`

## Requirements
- R1: While reset is asserted and after it is released, `speed_rpm` reads 0 and `speed_vld` reads 0 until the first window closes.
- R2: `speed_vld` pulses high for exactly one cycle every GATE cycles, where GATE = round(CLK_HZ*60/PULSES_PER_REV) (ties rounded up).
- R3: At each strobe, `speed_rpm` equals the number of low-to-high transitions of `enc_pulse` that were synchronized during the window just closed.
- R4: A level held high on `enc_pulse` counts as one event, at the transition only. A window in which the input stays high the whole time reports 0.
- R5: The count saturates at 2^CNT_W-1 and never wraps back to small values.
- R6: The count restarts from zero in each window, so a window with no transitions reports 0 whatever the previous window reported.
- R7: `speed_rpm` is held stable in every cycle in which `speed_vld` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_pulse | input | 1 | Raw encoder pulse, asynchronous to clk |
| speed_rpm | output | CNT_W | Speed latched at the end of the last window, in r/min |
| speed_vld | output | 1 | One-cycle strobe marking a new speed value |

## Verification
The hardest state to reach from the ports is saturation. It needs more transitions in one window than CNT_W can hold, and in the default setting that means thousands of edges across a window of more than a million cycles. The bench shortens the window by choosing a small clock-rate parameter and narrows CNT_W to 6 bits. It then drives one-cycle-high, one-cycle-low pulses back to back, which puts about a hundred edges into a 201-cycle window. The clock-rate parameter is chosen so that rounding and truncation give different gate lengths, so the measured strobe period also checks the rounding.

// File: rtl/enc_speed_pkg.sv
package enc_speed_pkg;

  // Gate window length in clock cycles: 60 s / pulses-per-rev, rounded.
  function automatic longint unsigned gate_len(input longint unsigned clk_hz,
                                               input longint unsigned ppr);
    return (clk_hz * 64'd60 + ppr / 64'd2) / ppr;
  endfunction

endpackage

// File: rtl/enc_pulse_sync.sv
module enc_pulse_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES-1:0] sh;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      prev <= 1'b0;
    end else begin
      sh   <= {sh[STAGES-2:0], din};
      prev <= sh[STAGES-1];
    end
  end

  assign rise = sh[STAGES-1] & ~prev;
endmodule

// File: rtl/enc_gate_timer.sv
module enc_gate_timer #(
  parameter int unsigned GATE = 1464844
) (
  input  logic clk,
  input  logic rst_n,
  output logic gate_end
);
  localparam int TW = (GATE > 1) ? $clog2(GATE) : 1;
  localparam logic [TW-1:0] LAST = TW'(GATE - 1);

  logic [TW-1:0] tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         tick <= '0;
    else if (gate_end)  tick <= '0;
    else                tick <= tick + 1'b1;
  end

  assign gate_end = (tick == LAST);
endmodule

// File: rtl/enc_edge_counter.sv
module enc_edge_counter #(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise,
  input  logic             gate_end,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] total
);
  localparam logic [CNT_W-1:0] MAXV = '1;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] c,
                                               input logic inc);
    if (inc && c != MAXV) return c + 1'b1;
    return c;
  endfunction

  assign total = sat_inc(cnt, rise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (gate_end) cnt <= '0;
    else               cnt <= total;
  end
endmodule

// File: rtl/enc_speed_meter.sv
module enc_speed_meter #(
  parameter longint unsigned CLK_HZ         = 25000000,
  parameter longint unsigned PULSES_PER_REV = 1024,
  parameter int              CNT_W          = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enc_pulse,
  output logic [CNT_W-1:0] speed_rpm,
  output logic             speed_vld
);
  localparam int unsigned GATE = int'(enc_speed_pkg::gate_len(CLK_HZ, PULSES_PER_REV));

  logic             rise;
  logic             gate_end;
  logic [CNT_W-1:0] win_cnt;
  logic [CNT_W-1:0] win_total;

  enc_pulse_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(enc_pulse), .rise(rise)
  );

  enc_gate_timer #(.GATE(GATE)) u_timer (
    .clk(clk), .rst_n(rst_n), .gate_end(gate_end)
  );

  enc_edge_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .rise(rise), .gate_end(gate_end),
    .cnt(win_cnt), .total(win_total)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      speed_rpm <= '0;
      speed_vld <= 1'b0;
    end else begin
      speed_vld <= gate_end;
      if (gate_end) speed_rpm <= win_total;
    end
  end
endmodule

// File: rtl/enc_speed_meter_chk.sv
module enc_speed_meter_chk #(
  parameter int          CNT_W = 13,
  parameter int unsigned GATE  = 1464844
) (
  input logic             clk,
  input logic             rst_n,
  input logic             speed_vld,
  input logic [CNT_W-1:0] speed_rpm,
  input logic [CNT_W-1:0] win_cnt,
  input logic             gate_end
);
  localparam logic [CNT_W-1:0] MAXV = '1;

  logic [31:0] since;
  logic        seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since <= '0;
      seen  <= 1'b0;
    end else begin
      since <= speed_vld ? 32'd0 : since + 32'd1;
      if (speed_vld) seen <= 1'b1;
    end
  end

  assert_strobe_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    speed_vld |=> !speed_vld);

  assert_strobe_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (speed_vld && seen) |-> (since == GATE - 1));

  assert_no_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (win_cnt == MAXV && !gate_end) |=> (win_cnt == MAXV));

  assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    gate_end |=> (win_cnt == '0));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !speed_vld |-> $stable(speed_rpm));
endmodule

bind enc_speed_meter enc_speed_meter_chk #(.CNT_W(CNT_W), .GATE(GATE)) u_chk (
  .clk(clk), .rst_n(rst_n), .speed_vld(speed_vld), .speed_rpm(speed_rpm),
  .win_cnt(win_cnt), .gate_end(gate_end)
);

// File: tb/enc_speed_meter_bench.sv
module enc_speed_meter_bench;
  localparam longint unsigned CLK_HZ = 3424;
  localparam longint unsigned PPR    = 1024;
  localparam int              CNT_W  = 6;
  // 3424*60/1024 = 200.625 -> rounds to 201 (truncation would give 200)
  localparam int G    = 201;
  localparam int MAXV = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             enc = 1'b0;
  logic [CNT_W-1:0] speed_rpm;
  logic             speed_vld;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  enc_speed_meter #(.CLK_HZ(CLK_HZ), .PULSES_PER_REV(PPR), .CNT_W(CNT_W)) u_enc_speed_meter (
    .clk(clk), .rst_n(rst_n), .enc_pulse(enc),
    .speed_rpm(speed_rpm), .speed_vld(speed_vld)
  );

  function automatic int exp_speed(input int edges);
    return (edges > MAXV) ? MAXV : edges;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Monitor: strobe period/width (R2) and hold between strobes (R7)
  int          since = 0;
  bit          seen  = 0;
  bit          prev_vld = 0;
  logic [CNT_W-1:0] prev_spd = '0;
  int          cyc = 0;

  always @(negedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      finish_run();
    end
    if (rst_n) begin
      if (speed_vld) begin
        if (seen) check("R2 period", since + 1, G);
        if (prev_vld) check("R2 width", 0, 1);
        seen  = 1;
        since = 0;
      end else begin
        since++;
        if (speed_rpm != prev_spd) check("R7 hold", int'(speed_rpm), int'(prev_spd));
      end
      prev_vld = speed_vld;
      prev_spd = speed_rpm;
    end
  end

  task automatic wait_strobe();
    do @(negedge clk); while (!speed_vld);
  endtask

  // Drive full pulses inside the window, leaving guard cycles at both ends.
  task automatic drive_burst(input int maxh, input int maxl, output int n);
    int budget = G - 14;
    n = 0;
    repeat (3) @(negedge clk);
    while (1) begin
      int h = 1 + int'($urandom % maxh);
      int l = 1 + int'($urandom % maxl);
      if (h + l > budget) break;
      enc = 1'b1;
      repeat (h) @(negedge clk);
      enc = 1'b0;
      repeat (l) @(negedge clk);
      budget -= h + l;
      n++;
    end
  endtask

  initial begin
    int n;
    void'($urandom(32'd7125));
    repeat (4) @(negedge clk);
    check("R1 reset speed", int'(speed_rpm), 0);
    check("R1 reset vld", int'(speed_vld), 0);
    rst_n = 1'b1;
    repeat (G / 2) @(negedge clk);
    check("R1 post-reset speed", int'(speed_rpm), 0);
    check("R1 post-reset vld", int'(speed_vld), 0);

    wait_strobe();
    check("R6 idle first window", int'(speed_rpm), 0);

    // Random sparse and moderate bursts (R3)
    for (int w = 0; w < 10; w++) begin
      drive_burst((w % 2) ? 6 : 3, (w % 2) ? 8 : 3, n);
      wait_strobe();
      check("R3 random burst", int'(speed_rpm), exp_speed(n));
    end

    // Dense burst: saturation (R5)
    drive_burst(1, 1, n);
    wait_strobe();
    check("R5 saturate", int'(speed_rpm), exp_speed(n));
    check("R5 burst exceeds max", int'(n > MAXV), 1);

    // Empty window after saturation: restart (R6)
    wait_strobe();
    check("R6 restart after saturate", int'(speed_rpm), 0);

    // Single pulse (R3 corner)
    repeat (5) @(negedge clk);
    enc = 1'b1; @(negedge clk); enc = 1'b0;
    wait_strobe();
    check("R3 single pulse", int'(speed_rpm), 1);

    // Held high level (R4)
    repeat (5) @(negedge clk);
    enc = 1'b1;
    wait_strobe();
    check("R4 rising level once", int'(speed_rpm), 1);
    wait_strobe();
    check("R4 steady high", int'(speed_rpm), 0);
    repeat (5) @(negedge clk);
    enc = 1'b0;
    wait_strobe();
    check("R4 falling only", int'(speed_rpm), 0);

    // More random bursts with mixed widths
    for (int w = 0; w < 6; w++) begin
      drive_burst(1 + w, 1 + (w % 3), n);
      wait_strobe();
      check("R3 mixed burst", int'(speed_rpm), exp_speed(n));
    end

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule